// File: doc/BRIEF.md
# Shifted Register-Offset Address Generator

This block forms the memory address of a load or store whose offset comes from a register. The offset value goes through a barrel shifter first. The shifted offset is then added to or subtracted from the base value. An indexing mode decides two things: which value goes to the memory port, and which value is offered as the new base. A legality checker enforces the shift set that each instruction-set state and transfer size allows. It raises a flag for any combination that is not encodable.

The block is purely combinational and is meant to sit in the execute stage between operand read and the memory port. No data flows through it as a stream, so it has no valid/ready handshake: every output follows its inputs within the same cycle. Instruction decoding, the register file and the memory access itself all belong to the surrounding pipeline.

Top module: `agen_regofs`

## Requirements
- R1: Shift kind encoding is 0 = LSL, 1 = LSR, 2 = ASR, 3 = ROR, 4 = RRX. The shifted offset is the offset register shifted by `shamt_i` in the selected way. ROR rotates right by `shamt_i` bits.
- R2: LSR by 32 gives 0 and ASR by 32 gives 32 copies of bit 31. In full state the legal amounts are: LSL 0–31, LSR and ASR 1–32, ROR 1–31, RRX 0 only. Any other amount sets `illegal_o`.
- R3: RRX shifts the offset right by one bit and puts `carry_i` into bit 31.
- R4: With `sub_i` = 1 the shifted offset is subtracted from the base; otherwise it is added. Subtraction is legal only in full state (`isa_i` = 0). In compact (1) or extended compact (2) state it sets `illegal_o`.
- R5: Mode encoding is 0 = offset, 1 = pre-indexed, 2 = post-indexed. Offset mode puts base±offset on `addr0_o` and keeps `wb_en_o` low. Pre-indexed mode puts base±offset on both `addr0_o` and `wb_val_o` and raises `wb_en_o`. Post-indexed mode puts the unmodified base on `addr0_o`, puts base±offset on `wb_val_o` and raises `wb_en_o`. In every mode `wb_val_o` carries base±offset.
- R6: Size encoding is 0 = word, 1 = unsigned byte, 2 = signed byte, 3 = unsigned halfword, 4 = signed halfword, 5 = doubleword. In full state, every size other than word and unsigned byte accepts only LSL #0. Any other shift sets `illegal_o`.
- R7: In compact state, sizes 0–4 accept only LSL 0–3 and the doubleword accepts only LSL #0. Everything else is illegal.
- R8: In extended compact state, a word needs exactly LSL #2, a halfword (either kind) needs exactly LSL #1, and a byte (either kind) needs LSL #0. A doubleword is illegal.
- R9: For a doubleword, `addr1_o` equals `addr0_o` + 4. For all other sizes, `addr1_o` equals `addr0_o`.
- R10: Mode 3, state 3, sizes 6–7 and shift kinds 5–7 are illegal. Whenever `illegal_o` is high, `wb_en_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| base_i | input | 32 | Base register value |
| ofs_i | input | 32 | Offset register value before shifting |
| carry_i | input | 1 | Carry flag, used by RRX |
| sub_i | input | 1 | 1 = subtract offset, 0 = add |
| shkind_i | input | 3 | Shift kind |
| shamt_i | input | 6 | Shift amount |
| mode_i | input | 2 | Indexing mode |
| isa_i | input | 2 | Instruction-set state |
| size_i | input | 3 | Transfer size |
| addr0_o | output | 32 | First access address |
| addr1_o | output | 32 | Second access address |
| wb_val_o | output | 32 | Value for base writeback |
| wb_en_o | output | 1 | Base writeback enable |
| illegal_o | output | 1 | Encoding not allowed |

## Verification
The bench targets the shift edges: amount 32 for LSR and ASR, amount 0 for the right shifts, and RRX with either carry value. A shifter that masks the amount to five bits would return the unshifted offset for a shift by 32 instead of zero or sign fill. The bench also probes the post-indexed mode, where a mixed-up multiplexer would send the updated base to memory. For the doubleword it checks that the second address is four above the first address, not above the base. Finally, the bench sweeps the per-state legality table, including the exact shift that extended compact state requires and subtraction outside full state, where a loose checker would let an illegal encoding write back.

// File: rtl/agen_pkg.sv
package agen_pkg;
  typedef enum logic [2:0] {SH_LSL = 3'd0, SH_LSR = 3'd1, SH_ASR = 3'd2,
                            SH_ROR = 3'd3, SH_RRX = 3'd4} shk_e;
  typedef enum logic [1:0] {MD_OFS = 2'd0, MD_PRE = 2'd1, MD_POST = 2'd2} mode_e;
  typedef enum logic [1:0] {IS_FULL = 2'd0, IS_CMP = 2'd1, IS_EXT = 2'd2} isa_e;
  typedef enum logic [2:0] {SZ_W = 3'd0, SZ_UB = 3'd1, SZ_SB = 3'd2,
                            SZ_UH = 3'd3, SZ_SH = 3'd4, SZ_DW = 3'd5} size_e;
endpackage

// File: rtl/agen_shifter.sv
module agen_shifter #(
  parameter int XLEN = 32,
  localparam int LOGW = $clog2(XLEN),
  localparam int SAW  = LOGW + 1
) (
  input  logic [XLEN-1:0] val_i,
  input  logic            carry_i,
  input  logic [2:0]      kind_i,
  input  logic [SAW-1:0]  amt_i,
  output logic [XLEN-1:0] res_o
);
  import agen_pkg::*;

  logic [2*XLEN-1:0] rot_w;
  logic [2*XLEN-1:0] rot_sh;
  logic [LOGW-1:0]   rot_amt;

  assign rot_w   = {val_i, val_i};
  assign rot_amt = amt_i[LOGW-1:0];
  assign rot_sh  = rot_w >> rot_amt;

  always_comb begin
    unique case (kind_i)
      SH_LSL:  res_o = val_i << amt_i;
      SH_LSR:  res_o = val_i >> amt_i;
      SH_ASR:  res_o = XLEN'($signed(val_i) >>> amt_i);
      SH_ROR:  res_o = rot_sh[XLEN-1:0];
      SH_RRX:  res_o = {carry_i, val_i[XLEN-1:1]};
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/agen_legal.sv
module agen_legal #(
  parameter int XLEN = 32,
  localparam int SAW = $clog2(XLEN) + 1
) (
  input  logic           sub_i,
  input  logic [2:0]     kind_i,
  input  logic [SAW-1:0] amt_i,
  input  logic [1:0]     mode_i,
  input  logic [1:0]     isa_i,
  input  logic [2:0]     size_i,
  output logic           illegal_o
);
  import agen_pkg::*;

  logic is_lsl, plain, lsl_ok, rng_ok, sz_ok, md_ok, isa_ok, form_ok;

  assign is_lsl = (kind_i == SH_LSL);
  assign plain  = is_lsl && (amt_i == '0);
  assign sz_ok  = (size_i <= SZ_DW);
  assign md_ok  = (mode_i <= MD_POST);
  assign isa_ok = (isa_i <= IS_EXT);
  assign lsl_ok = is_lsl && (amt_i <= SAW'(3));

  always_comb begin
    unique case (kind_i)
      SH_LSL:  rng_ok = amt_i < SAW'(XLEN);
      SH_LSR,
      SH_ASR:  rng_ok = (amt_i != '0) && (amt_i <= SAW'(XLEN));
      SH_ROR:  rng_ok = (amt_i != '0) && (amt_i < SAW'(XLEN));
      SH_RRX:  rng_ok = (amt_i == '0);
      default: rng_ok = 1'b0;
    endcase
  end

  always_comb begin
    form_ok = 1'b0;
    unique case (isa_i)
      IS_FULL: form_ok = (size_i == SZ_W || size_i == SZ_UB) ? rng_ok : plain;
      IS_CMP:  form_ok = !sub_i && ((size_i == SZ_DW) ? plain : lsl_ok);
      IS_EXT: begin
        unique case (size_i)
          SZ_W:         form_ok = is_lsl && (amt_i == SAW'(2));
          SZ_UH, SZ_SH: form_ok = is_lsl && (amt_i == SAW'(1));
          SZ_UB, SZ_SB: form_ok = plain;
          default:      form_ok = 1'b0;
        endcase
        if (sub_i) form_ok = 1'b0;
      end
      default: form_ok = 1'b0;
    endcase
  end

  assign illegal_o = !(sz_ok && md_ok && isa_ok && form_ok);
endmodule

// File: rtl/agen_regofs.sv
module agen_regofs #(
  parameter int XLEN      = 32,
  parameter int DW_STRIDE = 4,
  localparam int SAW      = $clog2(XLEN) + 1
) (
  input  logic [XLEN-1:0] base_i,
  input  logic [XLEN-1:0] ofs_i,
  input  logic            carry_i,
  input  logic            sub_i,
  input  logic [2:0]      shkind_i,
  input  logic [SAW-1:0]  shamt_i,
  input  logic [1:0]      mode_i,
  input  logic [1:0]      isa_i,
  input  logic [2:0]      size_i,
  output logic [XLEN-1:0] addr0_o,
  output logic [XLEN-1:0] addr1_o,
  output logic [XLEN-1:0] wb_val_o,
  output logic            wb_en_o,
  output logic            illegal_o
);
  import agen_pkg::*;

  logic [XLEN-1:0] shifted, eff;
  logic            bad;

  agen_shifter #(.XLEN(XLEN)) u_shift (
    .val_i(ofs_i), .carry_i(carry_i), .kind_i(shkind_i),
    .amt_i(shamt_i), .res_o(shifted)
  );

  agen_legal #(.XLEN(XLEN)) u_legal (
    .sub_i(sub_i), .kind_i(shkind_i), .amt_i(shamt_i),
    .mode_i(mode_i), .isa_i(isa_i), .size_i(size_i), .illegal_o(bad)
  );

  assign eff = sub_i ? (base_i - shifted) : (base_i + shifted);

  always_comb begin
    addr0_o = (mode_i == MD_POST) ? base_i : eff;
    wb_en_o = !bad && (mode_i == MD_PRE || mode_i == MD_POST);
  end

  assign addr1_o   = (size_i == SZ_DW) ? addr0_o + XLEN'(DW_STRIDE) : addr0_o;
  assign wb_val_o  = eff;
  assign illegal_o = bad;
endmodule

// File: rtl/agen_regofs_chk.sv
module agen_regofs_chk #(
  parameter int XLEN = 32,
  localparam int SAW = $clog2(XLEN) + 1
) (
  input logic [XLEN-1:0] base_i,
  input logic [2:0]      size_i,
  input logic [1:0]      mode_i,
  input logic [1:0]      isa_i,
  input logic            sub_i,
  input logic [XLEN-1:0] addr0_o,
  input logic [XLEN-1:0] addr1_o,
  input logic [XLEN-1:0] wb_val_o,
  input logic            wb_en_o,
  input logic            illegal_o
);
  always_comb begin
    if (mode_i == 2'd0)
      a_r5_offset_no_wb: assert (!wb_en_o) else $error("R5 offset wrote back");
    if (!illegal_o && mode_i == 2'd1)
      a_r5_pre_same: assert (addr0_o == wb_val_o) else $error("R5 pre mismatch");
    if (!illegal_o && mode_i == 2'd2)
      a_r5_post_base: assert (addr0_o == base_i) else $error("R5 post addr");
    if (size_i == 3'd5)
      a_r9_dw_stride: assert (addr1_o == addr0_o + XLEN'(4)) else $error("R9 stride");
    if (illegal_o)
      a_r10_no_wb: assert (!wb_en_o) else $error("R10 illegal wb");
    if (sub_i && isa_i != 2'd0)
      a_r4_sub_flag: assert (illegal_o) else $error("R4 sub accepted");
  end
endmodule

bind agen_regofs agen_regofs_chk #(.XLEN(XLEN)) u_chk (
  .base_i(base_i), .size_i(size_i), .mode_i(mode_i), .isa_i(isa_i),
  .sub_i(sub_i), .addr0_o(addr0_o), .addr1_o(addr1_o), .wb_val_o(wb_val_o),
  .wb_en_o(wb_en_o), .illegal_o(illegal_o)
);

// File: tb/agen_regofs_bench.sv
module agen_regofs_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] base, ofs;
  logic carry, sub;
  logic [2:0] kind, size;
  logic [5:0] amt;
  logic [1:0] mode, isa;
  logic [31:0] a0, a1, wv;
  logic we, ill;
  int compared = 0, mismatched = 0;
  bit done = 0;

  agen_regofs u_agen_regofs (
    .base_i(base), .ofs_i(ofs), .carry_i(carry), .sub_i(sub),
    .shkind_i(kind), .shamt_i(amt), .mode_i(mode), .isa_i(isa), .size_i(size),
    .addr0_o(a0), .addr1_o(a1), .wb_val_o(wv), .wb_en_o(we), .illegal_o(ill)
  );

  function automatic logic [31:0] m_shift(logic [2:0] k, int n, logic [31:0] v, logic c);
    logic [31:0] r = v;
    case (k)
      3'd0: repeat (n) r = r << 1;
      3'd1: repeat (n) r = r >> 1;
      3'd2: repeat (n) r = {r[31], r[31:1]};
      3'd3: repeat (n) r = {r[0], r[31:1]};
      3'd4: r = {c, v[31:1]};
      default: r = 0;
    endcase
    return r;
  endfunction

  function automatic bit m_legal(logic s, logic [2:0] k, int n, logic [1:0] md,
                                 logic [1:0] st, logic [2:0] sz);
    bit none = (k == 0 && n == 0);
    if (md > 2 || st > 2 || sz > 5 || k > 4) return 0;
    if (st != 0 && s) return 0;
    if (st == 0) begin
      if (sz > 1) return none;
      if (k == 0) return n <= 31;
      if (k == 1 || k == 2) return n >= 1 && n <= 32;
      if (k == 3) return n >= 1 && n <= 31;
      return n == 0;
    end
    if (st == 1) return (sz == 5) ? none : (k == 0 && n <= 3);
    if (sz == 0) return k == 0 && n == 2;
    if (sz == 3 || sz == 4) return k == 0 && n == 1;
    if (sz == 1 || sz == 2) return none;
    return 0;
  endfunction

  task automatic cmp(string tag, string what, logic [31:0] got, logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic apply(string tag, logic [31:0] b, logic [31:0] o, logic c, logic s,
                       logic [2:0] k, int n, logic [1:0] md, logic [1:0] st, logic [2:0] sz);
    logic [31:0] sh, e, x0, x1;
    bit lg, wen;
    @(posedge clk);
    #1;
    base = b; ofs = o; carry = c; sub = s; kind = k; amt = 6'(n);
    mode = md; isa = st; size = sz;
    sh = m_shift(k, n, o, c);
    e = s ? b - sh : b + sh;
    x0 = (md == 2) ? b : e;
    x1 = (sz == 5) ? x0 + 4 : x0;
    lg = m_legal(s, k, n, md, st, sz);
    wen = lg && (md == 1 || md == 2);
    @(negedge clk);
    cmp(tag, "addr0", a0, x0);
    cmp(tag, "addr1", a1, x1);
    cmp(tag, "wb_val", wv, e);
    cmp(tag, "wb_en", 32'(we), 32'(wen));
    cmp(tag, "illegal", 32'(ill), 32'(!lg));
  endtask

  initial begin
    #400000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: got hang expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    base = 0; ofs = 0; carry = 0; sub = 0; kind = 0; amt = 0; mode = 0; isa = 0; size = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    apply("R5", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    apply("R1", 32'h1000, 32'h3, 0, 0, 0, 4, 0, 0, 0);
    apply("R1", 32'h1000, 32'hF000_0001, 0, 0, 3, 4, 1, 0, 1);
    apply("R2", 32'h100, 32'h8000_0000, 0, 0, 1, 32, 0, 0, 0);
    apply("R2", 32'h100, 32'h8000_0000, 0, 0, 2, 32, 0, 0, 0);
    apply("R2", 32'h100, 32'h4, 0, 0, 1, 0, 0, 0, 0);
    apply("R2", 32'h100, 32'h4, 0, 0, 3, 32, 0, 0, 0);
    apply("R3", 32'h0, 32'h5, 1, 0, 4, 0, 0, 0, 0);
    apply("R3", 32'h0, 32'h5, 0, 0, 4, 0, 1, 0, 0);
    apply("R4", 32'h2000, 32'h10, 0, 1, 0, 2, 1, 0, 0);
    apply("R4", 32'h2000, 32'h10, 0, 1, 0, 2, 0, 1, 0);
    apply("R5", 32'h3000, 32'h8, 0, 0, 0, 1, 2, 0, 0);
    apply("R5", 32'h3000, 32'h8, 0, 1, 0, 1, 1, 0, 0);
    apply("R6", 32'h40, 32'h2, 0, 0, 0, 1, 0, 0, 3);
    apply("R6", 32'h40, 32'h2, 0, 1, 0, 0, 1, 0, 4);
    apply("R7", 32'h40, 32'h2, 0, 0, 0, 3, 1, 1, 2);
    apply("R7", 32'h40, 32'h2, 0, 0, 0, 4, 1, 1, 0);
    apply("R7", 32'h40, 32'h2, 0, 0, 0, 1, 2, 1, 5);
    apply("R8", 32'h80, 32'h3, 0, 0, 0, 2, 0, 2, 0);
    apply("R8", 32'h80, 32'h3, 0, 0, 0, 1, 0, 2, 0);
    apply("R8", 32'h80, 32'h3, 0, 0, 0, 1, 0, 2, 4);
    apply("R8", 32'h80, 32'h3, 0, 0, 0, 0, 0, 2, 5);
    apply("R9", 32'hFFFF_FFF8, 32'h4, 0, 0, 0, 0, 2, 0, 5);
    apply("R9", 32'h100, 32'h4, 0, 1, 0, 0, 1, 0, 5);
    apply("R10", 32'h100, 32'h4, 0, 0, 0, 0, 3, 0, 0);
    apply("R10", 32'h100, 32'h4, 0, 0, 0, 0, 1, 3, 0);
    apply("R10", 32'h100, 32'h4, 0, 0, 5, 0, 1, 0, 0);
    apply("R10", 32'h100, 32'h4, 0, 0, 0, 0, 2, 0, 6);
    for (int i = 0; i < 3000; i++)
      apply("R1", $urandom, $urandom, 1'($urandom), 1'($urandom), 3'($urandom_range(0, 5)),
            int'($urandom_range(0, 33)), 2'($urandom), 2'($urandom_range(0, 2)),
            3'($urandom_range(0, 6)));
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule